// File: doc/BRIEF.md
# Memory Region Access Checker

This block guards one slave port of an on-chip bus. It holds a parameterised set of region descriptors. Each descriptor has a start and end address on 32-byte granules, a rights word shared by eight bus masters, an 8-bit process tag with a don't-care mask, and a valid bit. Every bus access presents its address, master number, access type (read, write or fetch), privilege level and process tag. One clock later the block returns a grant or a deny, and a deny carries an error class.

Masters 0 to 3 carry full rights. Each has a user rwx code, a supervisor code that can point back to the user code, and a flag that filters region matching by process tag. Masters 4 to 7 carry only a read enable and a write enable. Several regions may overlap, and any one of the matching regions can grant the access. A global enable input turns the whole check off, and then every access is granted. Descriptors are programmed through a simple word-wide write port.

Top module: `region_guard`

## Requirements
- R1: A region's start address ignores bits [4:0] of the written value and treats them as 0. The first byte of the aligned 32-byte granule hits, and the byte just below it does not.
- R2: A region's end address treats bits [4:0] as 1, so the last byte of the 32-byte granule that holds the written end address still hits (inclusive), and the next byte does not.
- R3: Master n in 0..3 owns rights bits [6n+5:6n]: [2:0] user code (bit 2 read, bit 1 write, bit 0 fetch), [4:3] supervisor code, bit 5 process-tag filter enable. A user-mode access (acc_super=0) is allowed only if its type's bit is set in the user code.
- R4: A supervisor access from masters 0..3 uses the supervisor code: 0 gives read/write/fetch, 1 gives read/fetch, 2 gives read/write, 3 applies the user code.
- R5: Master n in 4..7 owns rights bits [24+2(n-4)+1 : 24+2(n-4)]: the low bit enables read and the high bit enables write. A fetch is never allowed, and acc_super has no effect.
- R6: When the accessing master's filter enable is set, a region hits only if acc_pid equals the region tag on every bit whose mask bit is 0. Masters 4..7 are never filtered.
- R7: A region with its valid bit clear never hits. When prot_en is 0, every access is granted with error class 0.
- R8: A denied access reports rsp_err: 1 when no region hits, 2 when exactly one region hits, 3 when two or more regions hit. A granted access reports 0.
- R9: When several regions hit, the access is granted if any one of them allows it.
- R10: rsp_valid follows acc_valid one cycle later. The result belongs to the inputs sampled at that edge. With no access, rsp_grant and rsp_err are 0. After reset every output is 0 and no region is valid.
- R11: Access type code 3 (acc_type: 0 read, 1 write, 2 fetch) is never granted while protection is enabled.
- R12: A write with cfg_we=1 updates the region cfg_region, and cfg_sel picks the field: 0 start, 1 end, 2 rights word, 3 tag word (bits [7:0] tag, [15:8] mask, bit 31 valid). Later accesses see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Global protection enable |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_region | input | RIDX_W | Descriptor index to write |
| cfg_sel | input | 2 | Field select of the write |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_master | input | 3 | Bus master number |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | 1 for supervisor mode |
| acc_pid | input | 8 | Process tag of the access |
| rsp_valid | output | 1 | Result present |
| rsp_grant | output | 1 | Access allowed |
| rsp_err | output | 2 | Deny class (0 when granted) |

## Verification
The assertions check on every cycle that the result tracks the access strobe with one cycle of latency, and that grant and error class are consistent. They also check that the global bypass always grants, and that fetches by plain masters and type-3 accesses are never granted. Rights decode, granule alignment at both ends, tag filtering under a mask, overlap resolution and the exact error class all depend on programmed descriptors. Only the bench's scenarios can show those.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W = 32,
  localparam int RIDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              cfg_we,
  input  logic [RIDX_W-1:0] cfg_region,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_master,
  input  logic [1:0]        acc_type,
  input  logic              acc_super,
  input  logic [7:0]        acc_pid,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_err
);
  localparam int GRAN = 5;
  localparam int TW = ADDR_W - GRAN;

  logic [TW-1:0]          lo_q [NUM_REGIONS];
  logic [TW-1:0]          hi_q [NUM_REGIONS];
  logic [31:0]            rights_q [NUM_REGIONS];
  logic [7:0]             tag_q [NUM_REGIONS];
  logic [7:0]             msk_q [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        lo_q[i]     <= '0;
        hi_q[i]     <= '0;
        rights_q[i] <= '0;
        tag_q[i]    <= '0;
        msk_q[i]    <= '0;
      end
    end else if (cfg_we && 32'(cfg_region) < NUM_REGIONS) begin
      case (cfg_sel)
        2'd0: lo_q[cfg_region]     <= cfg_wdata[ADDR_W-1:GRAN];
        2'd1: hi_q[cfg_region]     <= cfg_wdata[ADDR_W-1:GRAN];
        2'd2: rights_q[cfg_region] <= cfg_wdata;
        default: begin
          tag_q[cfg_region] <= cfg_wdata[7:0];
          msk_q[cfg_region] <= cfg_wdata[15:8];
          vld_q[cfg_region] <= cfg_wdata[31];
        end
      endcase
    end
  end

  logic [4:0] poff, noff;
  logic [2:0] need;
  assign poff = 5'(acc_master[1:0]) * 5'd6;
  assign noff = 5'd24 + {2'b00, acc_master[1:0], 1'b0};
  assign need = (acc_type == 2'd0) ? 3'b100 :
                (acc_type == 2'd1) ? 3'b010 :
                (acc_type == 2'd2) ? 3'b001 : 3'b000;

  logic [NUM_REGIONS-1:0] hit, allow;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic [5:0] pf;
    logic [1:0] nf;
    logic       in_rng, tag_ok;
    logic [2:0] rwx;

    assign pf = rights_q[g][poff +: 6];
    assign nf = rights_q[g][noff +: 2];
    assign in_rng = (acc_addr[ADDR_W-1:GRAN] >= lo_q[g]) &&
                    (acc_addr[ADDR_W-1:GRAN] <= hi_q[g]);
    assign tag_ok = acc_master[2] || !pf[5] ||
                    (((acc_pid ^ tag_q[g]) & ~msk_q[g]) == 8'h00);

    always_comb begin
      if (acc_master[2])    rwx = {nf[0], nf[1], 1'b0};
      else if (!acc_super)  rwx = pf[2:0];
      else begin
        case (pf[4:3])
          2'd0:    rwx = 3'b111;
          2'd1:    rwx = 3'b101;
          2'd2:    rwx = 3'b110;
          default: rwx = pf[2:0];
        endcase
      end
    end

    assign hit[g]   = vld_q[g] && in_rng && tag_ok;
    assign allow[g] = hit[g] && |(rwx & need);
  end

  logic multi;
  assign multi = (hit & (hit - 1'b1)) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_err   <= 2'd0;
    end else begin
      rsp_valid <= acc_valid;
      if (!acc_valid) begin
        rsp_grant <= 1'b0;
        rsp_err   <= 2'd0;
      end else if (!prot_en || |allow) begin
        rsp_grant <= 1'b1;
        rsp_err   <= 2'd0;
      end else begin
        rsp_grant <= 1'b0;
        rsp_err   <= (hit == '0) ? 2'd1 : (multi ? 2'd3 : 2'd2);
      end
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prot_en,
  input logic       acc_valid,
  input logic [2:0] acc_master,
  input logic [1:0] acc_type,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic [1:0] rsp_err
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == ($past(acc_valid) && $past(rst_n)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_grant && rsp_err == 2'd0));

  p_grant_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> rsp_err == 2'd0);

  p_deny_has_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> rsp_err != 2'd0);

  p_bypass_grants_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rst_n) && !$past(prot_en)) |-> rsp_grant);

  p_plain_no_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rst_n) && $past(prot_en) && $past(acc_master[2]) &&
     $past(acc_type) == 2'd2) |-> !rsp_grant);

  p_type3_denied_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rst_n) && $past(prot_en) && $past(acc_type) == 2'd3)
    |-> !rsp_grant);
endmodule

bind region_guard region_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .acc_valid(acc_valid),
  .acc_master(acc_master), .acc_type(acc_type), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_err(rsp_err)
);

// File: tb/region_guard_test.sv
module region_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_region = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_master = '0;
  logic [1:0]  acc_type = '0;
  logic        acc_super = 1'b0;
  logic [7:0]  acc_pid = '0;
  logic        rsp_valid, rsp_grant;
  logic [1:0]  rsp_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  region_guard uut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] addr;
    logic [2:0]  mst;
    logic [1:0]  typ;
    logic        sup;
    logic [7:0]  pid;
    logic        g;
    logic [1:0]  e;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  32'h1000_0000, 3'd0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0}, // R1 first byte
    '{4'd1,  32'h0FFF_FFFF, 3'd0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1}, // R1 byte below
    '{4'd2,  32'h1000_01FF, 3'd0, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0}, // R2 last byte
    '{4'd2,  32'h1000_0200, 3'd0, 2'd1, 1'b0, 8'h00, 1'b0, 2'd1}, // R2 past end
    '{4'd2,  32'h2000_001F, 3'd2, 2'd0, 1'b0, 8'h5A, 1'b1, 2'd0}, // R2 granule end
    '{4'd2,  32'h2000_0020, 3'd2, 2'd0, 1'b0, 8'h5A, 1'b0, 2'd1}, // R2
    '{4'd9,  32'h1000_00FF, 3'd0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0}, // R9 overlap, first allows
    '{4'd9,  32'h1000_0090, 3'd0, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0}, // R9 overlap, second allows
    '{4'd3,  32'h1000_0010, 3'd0, 2'd1, 1'b0, 8'h00, 1'b0, 2'd2}, // R3 user read-only
    '{4'd3,  32'h1000_0010, 3'd0, 2'd2, 1'b0, 8'h00, 1'b0, 2'd2}, // R3
    '{4'd3,  32'h1000_0010, 3'd1, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0}, // R3 user full
    '{4'd3,  32'h1000_0010, 3'd1, 2'd2, 1'b0, 8'h00, 1'b1, 2'd0}, // R3
    '{4'd4,  32'h1000_0010, 3'd0, 2'd1, 1'b1, 8'h00, 1'b1, 2'd0}, // R4 code 2 rw
    '{4'd4,  32'h1000_0010, 3'd0, 2'd2, 1'b1, 8'h00, 1'b0, 2'd2}, // R4 code 2 no fetch
    '{4'd4,  32'h1000_0010, 3'd1, 2'd2, 1'b1, 8'h00, 1'b1, 2'd0}, // R4 code 1 fetch
    '{4'd4,  32'h1000_0010, 3'd1, 2'd1, 1'b1, 8'h00, 1'b0, 2'd2}, // R4 code 1 no write
    '{4'd8,  32'h1000_0090, 3'd0, 2'd2, 1'b0, 8'h00, 1'b0, 2'd3}, // R8 overlap deny
    '{4'd4,  32'h1000_0090, 3'd0, 2'd2, 1'b1, 8'h00, 1'b0, 2'd3}, // R4 code 3 = user
    '{4'd5,  32'h1000_0010, 3'd4, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0}, // R5 m4 read
    '{4'd5,  32'h1000_0010, 3'd4, 2'd1, 1'b0, 8'h00, 1'b0, 2'd2}, // R5 m4 write
    '{4'd5,  32'h1000_0010, 3'd4, 2'd0, 1'b1, 8'h00, 1'b1, 2'd0}, // R5 mode ignored
    '{4'd5,  32'h1000_0010, 3'd5, 2'd1, 1'b1, 8'h00, 1'b1, 2'd0}, // R5 m5 write
    '{4'd5,  32'h1000_0010, 3'd5, 2'd0, 1'b0, 8'h00, 1'b0, 2'd2}, // R5 m5 read
    '{4'd5,  32'h1000_0010, 3'd4, 2'd2, 1'b1, 8'h00, 1'b0, 2'd2}, // R5 no fetch
    '{4'd5,  32'h1000_0010, 3'd6, 2'd0, 1'b0, 8'h00, 1'b0, 2'd2}, // R5 m6 none
    '{4'd6,  32'h2000_0000, 3'd2, 2'd0, 1'b0, 8'h53, 1'b1, 2'd0}, // R6 masked bits differ
    '{4'd6,  32'h2000_0000, 3'd2, 2'd0, 1'b0, 8'h4A, 1'b0, 2'd1}, // R6 unmasked bit differs
    '{4'd6,  32'h2000_0000, 3'd3, 2'd0, 1'b0, 8'h4A, 1'b0, 2'd2}, // R6 no filter on m3
    '{4'd7,  32'h3000_0000, 3'd0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1}, // R7 invalid region
    '{4'd11, 32'h1000_0010, 3'd1, 2'd3, 1'b1, 8'h00, 1'b0, 2'd2}  // R11 type 3
  };

  task automatic check(input string tag, input logic v, input logic g, input logic [1:0] e);
    total++;
    if (rsp_valid !== v || rsp_grant !== g || rsp_err !== e) begin
      bad++;
      $display("FAIL %s: got valid=%0b grant=%0b err=%0d, expected valid=%0b grant=%0b err=%0d",
               tag, rsp_valid, rsp_grant, rsp_err, v, g, e);
    end
  endtask

  task automatic wr(input int r, input int s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = 3'(r); cfg_sel = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [2:0] m, input logic [1:0] t,
                     input logic s, input logic [7:0] p);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_master = m; acc_type = t; acc_super = s; acc_pid = p;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", 1'b0, 1'b0, 2'd0);
    rst_n = 1'b1;

    acc(32'h1000_0000, 3'd0, 2'd0, 1'b0, 8'h00);
    check("R7 no valid region after reset", 1'b1, 1'b0, 2'd1);

    // R12 programming through every field select
    wr(0, 0, 32'h1000_0007); wr(0, 1, 32'h1000_00E0);
    wr(0, 2, 32'h0900_03D4); wr(0, 3, 32'h8000_0000);
    wr(1, 0, 32'h1000_0080); wr(1, 1, 32'h1000_01FF);
    wr(1, 2, 32'h0000_001A); wr(1, 3, 32'h8000_0000);
    wr(2, 0, 32'h2000_0000); wr(2, 1, 32'h2000_0000);
    wr(2, 2, 32'h0002_7000); wr(2, 3, 32'h8000_0F5A);
    wr(3, 0, 32'h3000_0000); wr(3, 1, 32'h3000_00FF);
    wr(3, 2, 32'h0000_0007); wr(3, 3, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].addr, VEC[i].mst, VEC[i].typ, VEC[i].sup, VEC[i].pid);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), 1'b1, VEC[i].g, VEC[i].e);
    end

    @(negedge clk);
    check("R10 idle cycle", 1'b0, 1'b0, 2'd0);

    prot_en = 1'b0;
    acc(32'h0000_0000, 3'd6, 2'd2, 1'b0, 8'h00);
    check("R7 global bypass grants", 1'b1, 1'b1, 2'd0);
    acc(32'h1000_0010, 3'd1, 2'd3, 1'b1, 8'h00);
    check("R7 bypass grants type 3", 1'b1, 1'b1, 2'd0);
    prot_en = 1'b1;

    wr(1, 3, 32'h0000_0000);
    acc(32'h1000_0090, 3'd0, 2'd2, 1'b0, 8'h00);
    check("R12 cleared valid turns overlap into single hit", 1'b1, 1'b0, 2'd2);
    acc(32'h1000_0090, 3'd0, 2'd1, 1'b0, 8'h00);
    check("R12 write no longer granted by removed region", 1'b1, 1'b0, 2'd2);

    wr(2, 3, 32'h8000_FF00);
    acc(32'h2000_0000, 3'd2, 2'd0, 1'b0, 8'h4A);
    check("R6 full mask matches any tag", 1'b1, 1'b1, 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule